// File: doc/BRIEF.md
# Two-Wire Register Write Target

This block is the target side of a two-wire serial control port that is compatible with SM-bus. A fast system clock oversamples the bus clock and data lines, and the block finds start and stop conditions in those samples. After a start it takes in a device-address byte. If the seven address bits name this device and the direction bit asks for a write, it acknowledges. It then receives three more bytes: a register address, then the high byte of a 16-bit data word, then the low byte. It acknowledges each of the three.

Only a frame that runs through its third data acknowledge reaches the outputs. At that point the block presents the register address and the data word and pulses a write strobe for one system-clock cycle. The register file that receives the write sits outside the block. The data line is modelled as an open-drain pair: an input level and an active-high pull-low enable.

A single select pin picks one of two device addresses. Several such targets can therefore share one bus.

Top module: `twi_reg_write_target`

## Requirements
- R1: A frame begins only with a start condition, which is the data line falling while the clock line is high. Bits clocked while no frame is open are ignored: there is no acknowledge and no write.
- R2: The first byte after a start is taken in MSB first: seven address bits, then the direction bit (0 means write). The device address is 0x1A when `addr_sel_i` is 0 and 0x1B when it is 1. On a match with direction 0, `sda_oe_o` is 1 while the clock is high in the ninth clock of that byte.
- R3: A device address that does not match, or a direction bit of 1, gets no acknowledge. The block then drives nothing for the rest of that frame and commits no write.
- R4: After the address is acknowledged, each of the three following bytes is acknowledged during its ninth clock.
- R5: After the ninth falling clock edge of the third byte, `wr_strobe_o` is 1 for exactly one system-clock cycle, before any stop. At that point `reg_addr_o` equals the first byte after the address, and `reg_data_o` equals the second byte (as bits 15..8) followed by the third byte (as bits 7..0).
- R6: A stop condition (the data line rising while the clock line is high) before the third acknowledge ends the frame. There is no strobe and the outputs are unchanged.
- R7: A start condition in the middle of a frame abandons the partial frame without a write and opens a new address phase.
- R8: `reg_addr_o` and `reg_data_o` change only in the cycle in which `wr_strobe_o` is 1, and otherwise hold the last committed write.
- R9: `sda_oe_o` changes only while the synchronized clock line is low. The acknowledge is released after the ninth falling edge, before the next bit is set up.
- R10: A synchronous active-high reset clears `sda_oe_o`, `wr_strobe_o`, `reg_addr_o` and `reg_data_o`, including when it arrives during an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low (acknowledge) |
| addr_sel_i | input | 1 | Device address select: 0 selects 0x1A, 1 selects 0x1B |
| reg_addr_o | output | 8 | Register address of the last committed write |
| reg_data_o | output | 16 | Data word of the last committed write |
| wr_strobe_o | output | 1 | One-cycle pulse per committed write |

## Verification
The bench builds the block with its default parameters. These are device addresses 0x1A and 0x1B, two synchronizer stages and a 16-bit data word, so both select-pin settings and both data bytes are exercised. The bus is driven at one twentieth of the system clock, which leaves margin above the minimum ratio of 8 once the synchronizer latency is counted. This means that an acknowledge that is set or released late shows up in the sampled ninth clock. Address mismatches that differ in the MSB and in the LSB, a read request, all-zero and all-one payloads, and aborts by stop, by repeated start and by reset all fall within reach.

// File: rtl/twi_tgt_pkg.sv
package twi_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RX   = 2'd1,
    ST_ACK  = 2'd2
  } twi_state_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_STAGES-1:0] scl_pipe;
  logic [SYNC_STAGES-1:0] sda_pipe;
  logic                   scl_prev;
  logic                   sda_prev;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= {scl_pipe[SYNC_STAGES-2:0], scl_i};
          sda_pipe <= {sda_pipe[SYNC_STAGES-2:0], sda_i};
        end
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst) begin
          scl_pipe <= '1;
          sda_pipe <= '1;
        end else begin
          scl_pipe <= scl_i;
          sda_pipe <= sda_i;
        end
      end
    end
  endgenerate

  assign scl_lvl = scl_pipe[SYNC_STAGES-1];
  assign sda_lvl = sda_pipe[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_prev <= scl_lvl;
      sda_prev <= sda_lvl;
    end
  end

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/twi_frame_fsm.sv
module twi_frame_fsm
  import twi_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_LO = 7'h1A,
  parameter logic [6:0] DEV_ADDR_HI = 7'h1B,
  parameter int         DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_lvl,
  input  logic              sda_lvl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              addr_sel,
  output logic              sda_oe,
  output logic              commit,
  output logic [BYTE_W-1:0] commit_addr,
  output logic [DATA_W-1:0] commit_data
);
  localparam int N_DATA_BYTES = DATA_W / BYTE_W;
  localparam int LAST_IDX     = 1 + N_DATA_BYTES;
  localparam int IDX_W        = $clog2(LAST_IDX + 1);
  localparam int ACC_W        = DATA_W - BYTE_W;
  localparam int CNT_W        = $clog2(BYTE_W + 1);

  twi_state_e        state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [IDX_W-1:0]  byte_idx_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] raddr_q;
  logic [ACC_W-1:0]  acc_q;
  logic              oe_q;
  logic [6:0]        my_addr;
  logic              addr_ok;
  logic              byte_done;
  logic              is_last;

  assign my_addr   = addr_sel ? DEV_ADDR_HI : DEV_ADDR_LO;
  assign addr_ok   = (shreg_q[BYTE_W-1:1] == my_addr) && !shreg_q[0];
  assign byte_done = scl_fall && (bit_cnt_q == CNT_W'(BYTE_W));
  assign is_last   = (byte_idx_q == IDX_W'(LAST_IDX));

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      shreg_q    <= '0;
      raddr_q    <= '0;
      acc_q      <= '0;
      oe_q       <= 1'b0;
    end else if (start_det) begin
      state_q    <= ST_RX;
      bit_cnt_q  <= '0;
      byte_idx_q <= '0;
      oe_q       <= 1'b0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else begin
      case (state_q)
        ST_RX: begin
          if (scl_rise && (bit_cnt_q < CNT_W'(BYTE_W))) begin
            shreg_q   <= {shreg_q[BYTE_W-2:0], sda_lvl};
            bit_cnt_q <= bit_cnt_q + CNT_W'(1);
          end else if (byte_done) begin
            if (byte_idx_q == '0) begin
              if (addr_ok) begin
                state_q <= ST_ACK;
                oe_q    <= 1'b1;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              if (byte_idx_q == IDX_W'(1)) raddr_q <= shreg_q;
              else if (!is_last) acc_q <= ACC_W'({acc_q, shreg_q});
              state_q <= ST_ACK;
              oe_q    <= 1'b1;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            oe_q <= 1'b0;
            if (is_last) begin
              state_q <= ST_IDLE;
            end else begin
              state_q    <= ST_RX;
              bit_cnt_q  <= '0;
              byte_idx_q <= byte_idx_q + IDX_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe      = oe_q;
  assign commit      = (state_q == ST_ACK) && scl_fall && is_last && !start_det && !stop_det;
  assign commit_addr = raddr_q;
  assign commit_data = {acc_q, shreg_q};

  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    stop_det && !start_det |=> (state_q == ST_IDLE) && !oe_q); // R6
  AST_START_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    start_det |=> (state_q == ST_RX) && (bit_cnt_q == '0) && (byte_idx_q == '0)); // R7
  AST_OE_SCL_LOW: assert property (@(posedge clk) disable iff (rst)
    (oe_q != $past(oe_q)) |-> !$past(scl_lvl)); // R9
  AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (rst)
    $rose(oe_q) |-> ($past(bit_cnt_q) == CNT_W'(BYTE_W))); // R4
endmodule

// File: rtl/twi_reg_write_target.sv
module twi_reg_write_target
  import twi_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR_LO = 7'h1A,
  parameter logic [6:0] DEV_ADDR_HI = 7'h1B,
  parameter int         SYNC_STAGES = 2,
  parameter int         DATA_W      = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe_o,
  input  logic              addr_sel_i,
  output logic [BYTE_W-1:0] reg_addr_o,
  output logic [DATA_W-1:0] reg_data_o,
  output logic              wr_strobe_o
);
  logic              scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic              commit;
  logic [BYTE_W-1:0] commit_addr;
  logic [DATA_W-1:0] commit_data;

  twi_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  twi_frame_fsm #(
    .DEV_ADDR_LO(DEV_ADDR_LO), .DEV_ADDR_HI(DEV_ADDR_HI), .DATA_W(DATA_W)
  ) u_fsm (
    .clk(clk), .rst(rst), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
    .stop_det(stop_det), .addr_sel(addr_sel_i), .sda_oe(sda_oe_o),
    .commit(commit), .commit_addr(commit_addr), .commit_data(commit_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_strobe_o <= 1'b0;
      reg_addr_o  <= '0;
      reg_data_o  <= '0;
    end else begin
      wr_strobe_o <= commit;
      if (commit) begin
        reg_addr_o <= commit_addr;
        reg_data_o <= commit_data;
      end
    end
  end

  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    wr_strobe_o |=> !wr_strobe_o); // R5
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_strobe_o |-> $stable(reg_addr_o) && $stable(reg_data_o)); // R8
endmodule

// File: tb/twi_reg_write_target_bench.sv
module twi_reg_write_target_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        addr_sel = 1'b0;
  logic        sda_oe;
  logic        sda_line;
  logic [7:0]  reg_addr;
  logic [15:0] reg_data;
  logic        wr_strobe;

  int n_chk = 0;
  int n_fail = 0;
  int strobe_cnt = 0;
  int double_cnt = 0;
  logic strobe_prev = 1'b0;
  logic [7:0]  exp_addr = '0;
  logic [15:0] exp_data = '0;

  always #5 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  twi_reg_write_target u_twi_reg_write_target (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe_o(sda_oe),
    .addr_sel_i(addr_sel), .reg_addr_o(reg_addr), .reg_data_o(reg_data),
    .wr_strobe_o(wr_strobe)
  );

  always @(negedge clk) begin
    if (rst) strobe_prev <= 1'b0;
    else begin
      if (wr_strobe) strobe_cnt++;
      if (wr_strobe && strobe_prev) double_cnt++;
      strobe_prev <= wr_strobe;
    end
  end

  // {sel, dev7, rw, reg addr, data16, expect ack}
  localparam logic [33:0] VEC [8] = '{
    {1'b0, 7'h1A, 1'b0, 8'h05, 16'hA55A, 1'b1},
    {1'b1, 7'h1B, 1'b0, 8'h7F, 16'h0001, 1'b1},
    {1'b0, 7'h1B, 1'b0, 8'h11, 16'h2222, 1'b0},
    {1'b1, 7'h1A, 1'b0, 8'h12, 16'h3333, 1'b0},
    {1'b0, 7'h1A, 1'b1, 8'h13, 16'h4444, 1'b0},
    {1'b0, 7'h1A, 1'b0, 8'hFF, 16'hFFFF, 1'b1},
    {1'b1, 7'h1B, 1'b0, 8'h00, 16'h0000, 1'b1},
    {1'b0, 7'h5A, 1'b0, 8'h21, 16'h5555, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(5);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b0; tick(10);
    scl_m = 1'b0; tick(5);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(5);
    scl_m = 1'b1; tick(10);
    sda_m = 1'b1; tick(10);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(5);
      scl_m = 1'b1; tick(10);
      scl_m = 1'b0; tick(5);
    end
  endtask

  task automatic ack_slot(output logic acked, output logic released);
    sda_m = 1'b1; tick(5);
    scl_m = 1'b1; tick(5);
    acked = sda_oe; tick(5);
    scl_m = 1'b0; tick(5);
    released = ~sda_oe;
  endtask

  task automatic frame_body(input logic [7:0] first, input logic [7:0] ra,
                            input logic [15:0] d, output logic [3:0] acks);
    logic a, rel;
    acks = '0;
    send_byte(first); ack_slot(a, rel); acks[0] = a;
    if (a) begin
      chk(rel, "R9 addr ack release", {31'd0, rel}, 32'd1);
      send_byte(ra);      ack_slot(a, rel); acks[1] = a;
      send_byte(d[15:8]); ack_slot(a, rel); acks[2] = a;
      send_byte(d[7:0]);  ack_slot(a, rel); acks[3] = a;
      chk(rel, "R9 last ack release", {31'd0, rel}, 32'd1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [3:0] acks;
    logic a, rel;
    int base;
    tick(4);
    // R10 reset state
    chk(!sda_oe && !wr_strobe, "R10 reset outputs", {30'd0, sda_oe, wr_strobe}, 32'd0);
    chk(reg_addr == 8'h00 && reg_data == 16'h0000, "R10 reset regs", {8'd0, reg_addr, reg_data}, 32'd0);
    rst = 1'b0; tick(4);

    // R1: bits without a start are ignored
    addr_sel = 1'b0;
    base = strobe_cnt;
    send_byte(8'h34); ack_slot(a, rel);
    chk(!a, "R1 no ack without start", {31'd0, a}, 32'd0);
    tick(20);
    bus_stop();

    // table walk: R2 R3 R4 R5
    foreach (VEC[k]) begin
      addr_sel = VEC[k][33];
      base = strobe_cnt;
      bus_start();
      frame_body({VEC[k][32:26], VEC[k][25]}, VEC[k][24:17], VEC[k][16:1], acks);
      chk(strobe_cnt == base + (VEC[k][0] ? 1 : 0), "R5 strobe before stop", strobe_cnt - base, {31'd0, VEC[k][0]});
      bus_stop();
      if (VEC[k][0]) begin
        exp_addr = VEC[k][24:17];
        exp_data = VEC[k][16:1];
        chk(acks == 4'hF, "R2 R4 all bytes acked", {28'd0, acks}, 32'hF);
      end else begin
        chk(acks == 4'h0, "R3 no ack on mismatch or read", {28'd0, acks}, 32'h0);
      end
      chk(reg_addr == exp_addr, "R5 R8 register address", {24'd0, reg_addr}, {24'd0, exp_addr});
      chk(reg_data == exp_data, "R5 R8 data word", {16'd0, reg_data}, {16'd0, exp_data});
    end

    // R6: stop after the high data byte aborts the write
    addr_sel = 1'b0;
    base = strobe_cnt;
    bus_start();
    send_byte(8'h34); ack_slot(a, rel);
    send_byte(8'h66); ack_slot(a, rel);
    send_byte(8'h77); ack_slot(a, rel);
    chk(a, "R4 high byte acked", {31'd0, a}, 32'd1);
    bus_stop();
    chk(strobe_cnt == base, "R6 no strobe after stop abort", strobe_cnt - base, 32'd0);
    chk(reg_addr == exp_addr && reg_data == exp_data, "R6 R8 outputs held",
        {8'd0, reg_addr, reg_data}, {8'd0, exp_addr, exp_data});

    // R7: a repeated start abandons the partial frame
    base = strobe_cnt;
    bus_start();
    send_byte(8'h34); ack_slot(a, rel);
    send_byte(8'h44); ack_slot(a, rel);
    bus_start();
    frame_body(8'h34, 8'h55, 16'hBEEF, acks);
    bus_stop();
    chk(strobe_cnt == base + 1, "R7 single strobe after restart", strobe_cnt - base, 32'd1);
    chk(reg_addr == 8'h55 && reg_data == 16'hBEEF, "R7 new frame committed",
        {8'd0, reg_addr, reg_data}, {8'd0, 8'h55, 16'hBEEF});

    // R5: strobe was never longer than one cycle
    chk(double_cnt == 0, "R5 strobe width", double_cnt, 32'd0);

    // R10: reset while the acknowledge is driven
    bus_start();
    send_byte(8'h34);
    sda_m = 1'b1; tick(5);
    scl_m = 1'b1; tick(5);
    chk(sda_oe, "R2 ack driven before reset", {31'd0, sda_oe}, 32'd1);
    rst = 1'b1; tick(2);
    chk(!sda_oe, "R10 reset releases data line", {31'd0, sda_oe}, 32'd0);
    chk(reg_addr == 8'h00 && reg_data == 16'h0000 && !wr_strobe, "R10 reset clears outputs",
        {7'd0, wr_strobe, reg_addr, reg_data}, 32'd0);
    rst = 1'b0; tick(5);
    scl_m = 1'b0; tick(5);
    bus_stop();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule